// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the purely combinational integer unit that executes the sixteen data-processing operations of a 32-bit core pipeline. It receives an operation code, a first operand from the register file, a second operand that has already passed through the barrel shifter, and the shifter's carry-out. From these it produces the operation result, an enable telling the pipeline whether that result goes to the destination register, and a fresh set of negative, zero, carry and overflow flags with a strobe that says whether the flag register should take them.

There are four operation classes. Plain and carry-chained arithmetic covers forward and reverse subtraction. Bitwise logic includes the move and move-inverted forms. The test and compare class evaluates an expression only for its flags. The carry flag comes from the adder for arithmetic and from the shifter for everything else. Overflow is reported for arithmetic only and otherwise keeps its previous value. No state is held inside the block, so the outputs follow the inputs in the same cycle.

Top module: `dp_alu`

## Requirements
- R1: Opcode encodings are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. ADD gives a+b, SUB gives a-b and RSB gives b-a, all modulo 2^32.
- R2: The carry-chained forms use the incoming C flag: ADC gives a+b+C, SBC gives a-b-(1-C), RSC gives b-a-(1-C).
- R3: AND, EOR, ORR give the bitwise and, xor and or of a and b. BIC gives a and not b. MOV gives b. MVN gives not b.
- R4: TST, TEQ, CMP and CMN evaluate a and b, a xor b, a-b and a+b. They never assert the result write enable, and they always assert the flag update strobe. Every other opcode asserts the write enable.
- R5: For opcodes outside the compare class, the flag update strobe equals the set-flags input.
- R6: N equals bit 31 of the evaluated value, and Z is 1 exactly when all 32 bits of that value are zero. This holds for compare operations too.
- R7: For arithmetic and arithmetic compares, C is the adder carry-out. In subtraction, C=1 means no borrow, that is, the minuend is not smaller than the subtrahend plus any borrow-in.
- R8: For logical, move and test operations, C equals the shifter carry input.
- R9: For arithmetic and arithmetic compares, V is 1 when the two's-complement result does not fit in 32 bits. For the other operations, V equals the incoming V flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (encoding in R1) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, already shifted |
| shc_i | input | 1 | Carry-out of the barrel shifter |
| c_i | input | 1 | Current C flag |
| v_i | input | 1 | Current V flag |
| s_i | input | 1 | Set-flags request of the instruction |
| res_o | output | 32 | Evaluated value |
| wr_o | output | 1 | Destination write enable |
| flag_upd_o | output | 1 | Flag register update strobe |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| c_o | output | 1 | New C flag |
| v_o | output | 1 | New V flag |

## Verification
Random opcodes, operands and flag inputs are mixed with operands biased toward 0, all ones, and the largest positive and negative values. This bias lands often on carry, borrow and overflow boundaries. Directed cases separate the carry-out from the shifter carry by giving them opposite values. Equal and off-by-one subtractions check the no-borrow sense of C. Sums on the signed boundary check V. A compare with the set-flags input low, and a move with it low, separate the forced flag update from the optional one. Each vector is checked against a model that computes results with wide signed and unsigned arithmetic rather than an adder chain.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic     arith;
    logic     cmp;
    logic     inv_a;
    logic     inv_b;
    cin_sel_e cin;
  } alu_ctl_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '{arith: 1'b0, cmp: 1'b0, inv_a: 1'b0, inv_b: 1'b0, cin: CIN_ZERO};
    unique case (alu_op_e'(op_i))
      OP_ADD: ctl_o.arith = 1'b1;
      OP_ADC: begin ctl_o.arith = 1'b1; ctl_o.cin = CIN_FLAG; end
      OP_SUB: begin ctl_o.arith = 1'b1; ctl_o.inv_b = 1'b1; ctl_o.cin = CIN_ONE; end
      OP_SBC: begin ctl_o.arith = 1'b1; ctl_o.inv_b = 1'b1; ctl_o.cin = CIN_FLAG; end
      OP_RSB: begin ctl_o.arith = 1'b1; ctl_o.inv_a = 1'b1; ctl_o.cin = CIN_ONE; end
      OP_RSC: begin ctl_o.arith = 1'b1; ctl_o.inv_a = 1'b1; ctl_o.cin = CIN_FLAG; end
      OP_CMP: begin
        ctl_o.arith = 1'b1; ctl_o.cmp = 1'b1;
        ctl_o.inv_b = 1'b1; ctl_o.cin = CIN_ONE;
      end
      OP_CMN: begin ctl_o.arith = 1'b1; ctl_o.cmp = 1'b1; end
      OP_TST, OP_TEQ: ctl_o.cmp = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_a_i,
  input  logic         inv_b_i,
  input  cin_sel_e     cin_sel_i,
  input  logic         c_flag_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    x = inv_a_i ? ~a_i : a_i;
    y = inv_b_i ? ~b_i : b_i;
    unique case (cin_sel_i)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = c_flag_i;
      default:  cin = 1'b0;
    endcase
    wide   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    // signed overflow: both inputs agree in sign and the sum disagrees
    ovf_o  = (x[W-1] == y[W-1]) && (sum_o[W-1] != x[W-1]);
  end

  logic [W:0] sx_sum;
  always_comb begin
    sx_sum = {x[W-1], x} + {y[W-1], y} + {{W{1'b0}}, cin};
    if (!$isunknown({a_i, b_i, inv_a_i, inv_b_i, cin_sel_i, c_flag_i})) begin
      if (inv_b_i && !inv_a_i && cin_sel_i == CIN_ONE)
        AST_SUB_NO_BORROW: assert (cout_o == (a_i >= b_i)); // R7
      if (inv_a_i && !inv_b_i && cin_sel_i == CIN_ONE)
        AST_RSB_NO_BORROW: assert (cout_o == (b_i >= a_i)); // R7
      AST_OVF_SIGNED: assert (ovf_o == (sx_sum[W] ^ sx_sum[W-1])); // R9
    end
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         shc_i,
  input  logic         c_i,
  input  logic         v_i,
  input  logic         s_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic         flag_upd_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o
);

  alu_ctl_t     ctl;
  logic [W-1:0] sum, lres;
  logic         cout, ovf;

  dp_alu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  dp_alu_adder #(.W(W)) u_add (
    .a_i       (a_i),
    .b_i       (b_i),
    .inv_a_i   (ctl.inv_a),
    .inv_b_i   (ctl.inv_b),
    .cin_sel_i (ctl.cin),
    .c_flag_i  (c_i),
    .sum_o     (sum),
    .cout_o    (cout),
    .ovf_o     (ovf)
  );

  dp_alu_logic #(.W(W)) u_log (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lres)
  );

  always_comb begin
    res_o      = ctl.arith ? sum : lres;
    wr_o       = ~ctl.cmp;
    flag_upd_o = s_i | ctl.cmp;
    n_o        = res_o[W-1];
    z_o        = (res_o == '0);
    c_o        = ctl.arith ? cout : shc_i;
    v_o        = ctl.arith ? ovf : v_i;
  end

  always_comb begin
    if (!$isunknown({op_i, s_i, v_i, shc_i})) begin
      if (op_i[3:2] == 2'b10)
        AST_CMP_NO_WRITE: assert (!wr_o && flag_upd_o); // R4
      if (op_i[3:2] != 2'b10)
        AST_FLAG_STROBE: assert (flag_upd_o == s_i); // R5
      if (!(op_i inside {[4'd2:4'd7], 4'd10, 4'd11}))
        AST_LOGIC_FLAGS: assert (v_o == v_i && c_o == shc_i); // R8
    end
  end

endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic        shc, cf, vf, sf;
  logic [31:0] res;
  logic        wr, upd, n, z, c, v;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dp_alu u_dut (
    .op_i(op), .a_i(a), .b_i(b), .shc_i(shc), .c_i(cf), .v_i(vf), .s_i(sf),
    .res_o(res), .wr_o(wr), .flag_upd_o(upd),
    .n_o(n), .z_o(z), .c_o(c), .v_o(v)
  );

  typedef struct {
    logic [31:0] r;
    logic wr, upd, n, z, c, v;
  } exp_t;

  function automatic bit is_arith(input logic [3:0] o);
    return (o >= 4'd2 && o <= 4'd7) || o == 4'd10 || o == 4'd11;
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                 input logic sc, input logic ci, input logic vi, input logic si);
    exp_t e;
    longint ux = longint'(x), uy = longint'(y);
    longint sx = longint'($signed(x)), sy = longint'($signed(y));
    longint bw = ci ? 0 : 1;
    longint sres = 0;
    e.c = sc; e.v = vi;
    case (o)
      4'd4, 4'd11: begin e.r = x + y; e.c = (ux + uy) > 64'hFFFF_FFFF; sres = sx + sy; end
      4'd5: begin e.r = x + y + 32'(ci); e.c = (ux + uy + longint'(ci)) > 64'hFFFF_FFFF;
                  sres = sx + sy + longint'(ci); end
      4'd2, 4'd10: begin e.r = x - y; e.c = ux >= uy; sres = sx - sy; end
      4'd6: begin e.r = x - y - 32'(bw); e.c = ux >= uy + bw; sres = sx - sy - bw; end
      4'd3: begin e.r = y - x; e.c = uy >= ux; sres = sy - sx; end
      4'd7: begin e.r = y - x - 32'(bw); e.c = uy >= ux + bw; sres = sy - sx - bw; end
      4'd0, 4'd8: e.r = x & y;
      4'd1, 4'd9: e.r = x ^ y;
      4'd12: e.r = x | y;
      4'd13: e.r = y;
      4'd14: e.r = x & ~y;
      default: e.r = ~y;
    endcase
    if (is_arith(o)) e.v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    e.wr  = !(o >= 4'd8 && o <= 4'd11);
    e.upd = si || !e.wr;
    e.n   = e.r[31];
    e.z   = (e.r == 32'd0);
    return e;
  endfunction

  function automatic string res_tag(input logic [3:0] o);
    if (o inside {4'd5, 4'd6, 4'd7}) return "R2";
    if (o inside {4'd2, 4'd3, 4'd4}) return "R1";
    if (o >= 4'd8 && o <= 4'd11) return "R4";
    return "R3";
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic sc, input logic ci, input logic vi, input logic si);
    exp_t e;
    bit bad;
    @(negedge clk);
    op = o; a = x; b = y; shc = sc; cf = ci; vf = vi; sf = si;
    @(posedge clk); #1;
    e = model(o, x, y, sc, ci, vi, si);
    n_vec++;
    bad = 0;
    if (res !== e.r) begin
      $display("FAIL %s op=%0d res act=%h exp=%h", res_tag(o), o, res, e.r); bad = 1;
    end
    if (wr !== e.wr) begin
      $display("FAIL R4 op=%0d wr act=%b exp=%b", o, wr, e.wr); bad = 1;
    end
    if (upd !== e.upd) begin
      $display("FAIL %s op=%0d upd act=%b exp=%b", e.wr ? "R5" : "R4", o, upd, e.upd); bad = 1;
    end
    if (n !== e.n || z !== e.z) begin
      $display("FAIL R6 op=%0d nz act=%b%b exp=%b%b", o, n, z, e.n, e.z); bad = 1;
    end
    if (c !== e.c) begin
      $display("FAIL %s op=%0d c act=%b exp=%b", is_arith(o) ? "R7" : "R8", o, c, e.c); bad = 1;
    end
    if (v !== e.v) begin
      $display("FAIL R9 op=%0d v act=%b exp=%b", o, v, e.v); bad = 1;
    end
    if (bad) n_fail++;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    op = 4'd0; a = '0; b = '0; shc = 0; cf = 0; vf = 0; sf = 0;
    // reset-like idle state: AND of zeros, no flag request
    apply(4'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);            // R3 R5 R6
    // R1 R7 R6: wrap to zero with carry, shifter carry opposite
    apply(4'd4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R9: positive overflow on add
    apply(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b1, 1'b0, 1'b0, 1'b1);
    // R7: equal subtraction, no borrow
    apply(4'd2, 32'h1234, 32'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
    // R7: borrow case 0-1
    apply(4'd2, 32'h0, 32'h1, 1'b1, 1'b1, 1'b0, 1'b1);
    // R9: negative overflow on subtract
    apply(4'd2, 32'h8000_0000, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R1: reverse subtract
    apply(4'd3, 32'h5, 32'h3, 1'b0, 1'b0, 1'b0, 1'b1);
    // R2: carry-chained forms with C=0 and C=1
    apply(4'd5, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    apply(4'd6, 32'h5, 32'h5, 1'b0, 1'b0, 1'b0, 1'b1);
    apply(4'd6, 32'h5, 32'h5, 1'b0, 1'b1, 1'b0, 1'b1);
    apply(4'd7, 32'h5, 32'h5, 1'b1, 1'b0, 1'b1, 1'b1);
    // R4: compare with S low still updates flags, no write
    apply(4'd10, 32'h3, 32'h3, 1'b0, 1'b0, 1'b1, 1'b0);
    apply(4'd11, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    apply(4'd8, 32'hF0, 32'h0F, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(4'd9, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0, 1'b1, 1'b0, 1'b0);
    // R5 R8: move with S low; move-inverted, BIC with S high
    apply(4'd13, 32'h0, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(4'd15, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    apply(4'd14, 32'hFF00_FF00, 32'hF0F0_F0F0, 1'b0, 1'b1, 1'b1, 1'b1);
    apply(4'd12, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    apply(4'd1, 32'h8000_0001, 32'h1, 1'b0, 1'b1, 1'b1, 1'b1);
    // constrained random sweep over all opcodes
    for (int i = 0; i < 4000; i++) begin
      apply(4'($urandom_range(0, 15)), pick(), pick(),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule